// File: doc/BRIEF.md
# Event Interval Measurement Timer

This block measures the time between asynchronous external events, such as pulses from a peak detector, at a resolution of one millisecond. A divider chain built from three cascaded stages produces one tick per millisecond from the system clock. The stages are an instruction-rate divider, a prescaler and a power-of-two overflow stage. Each tick advances a 16-bit jiffy counter.

A rising edge on the event input is first brought into the clock domain. It then copies the whole jiffy count into a result register in a single step. The same edge restarts both the counter and the divider chain from zero, so each event opens the next interval. A ready flag tells a polling consumer that a fresh interval is waiting. The consumer clears the flag with a one-cycle read strobe. If a second capture arrives before that strobe, a sticky overrun bit records the lost value.

The counter and divider do not need to be cleared at reset, because the first interval is never aligned to the events anyway. A parameter can add a reset to them if it is wanted. The flags are always reset.

Top module: `evt_interval_timer`

## Requirements
- R1: A tick occurs once every INSTR_DIV*PRESCALE*2^OVF_BITS clock cycles, which is 4096 cycles (1 ms at 4.096 MHz) with the defaults, and each tick advances the jiffy counter by one.
- R2: The event input passes through SYNC_STAGES flip-flops and a rising-edge detector. Each low-to-high transition causes exactly one capture, however long the input stays high. With two stages, the capture takes effect at the third rising clock edge that samples the input high.
- R3: A capture copies the full 16-bit count to `interval_o` in one step, and `interval_o` holds its value between captures.
- R4: A capture zeroes both the jiffy counter and the divider chain. Two events whose captures lie G cycles apart therefore report floor((G-1)/P), where P is the tick period.
- R5: When a tick and a capture fall in the same cycle, the captured value is the count before that tick, and the counter restarts at zero.
- R6: A capture sets `ready_o`, and a one-cycle `rd_ack_i` clears it. If the strobe and a capture share a cycle, `ready_o` stays set and no overrun is recorded.
- R7: A capture while `ready_o` is set and without a strobe in the same cycle sets `overrun_o`. The bit stays set until `rd_ack_i` clears it.
- R8: Reset clears `ready_o` and `overrun_o`. The counter, the divider and the result are cleared only when CLEAR_ON_RESET is 1.
- R9: The jiffy counter wraps from FFFFh to 0000h and does not saturate.
- R10: `rd_ack_i` while `ready_o` is clear has no effect on `ready_o`, `overrun_o` or `interval_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Asynchronous event input; a rising edge ends one interval and starts the next |
| rd_ack_i | input | 1 | One-cycle read strobe from the consumer; clears the ready and overrun flags |
| interval_o | output | CNT_W | Last captured interval, in ticks |
| ready_o | output | 1 | A fresh interval is waiting |
| overrun_o | output | 1 | A captured interval was overwritten before it was read (sticky) |

## Verification
The checker watches the tick spacing and the count behaviour on every cycle. The count must step by one on a tick, hold otherwise, wrap at full scale and restart at zero on a capture. The checker also verifies that a capture copies the pre-capture count, that the result holds between captures, and that the ready and overrun flags change as R6 and R7 require. Only the bench scenarios can show the measured intervals seen from the ports, which need the end-to-end latency of the event input. The bench scenarios also cover single capture for a long event pulse, the ordering of a read strobe that coincides with a capture, the wrap after more than 65536 ticks, and the flag state during reset.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   // Handshake flags seen by the polling consumer.
   typedef struct packed {
      logic ready;
      logic overrun;
   } hs_flags_t;

   // Number of cascaded stages in the tick divider chain.
   localparam int TICK_STAGES = 3;

   // Counter width needed by a divide-by-div stage.
   function automatic int stage_width(input int div);
      return (div > 1) ? $clog2(div) : 1;
   endfunction

   // Divide ratio of stage g: instruction divide, prescale, overflow.
   function automatic int stage_ratio(input int g, input int instr_div,
                                      input int prescale, input int ovf_bits);
      case (g)
         0:       return instr_div;
         1:       return prescale;
         default: return 1 << ovf_bits;
      endcase
   endfunction

endpackage

// File: rtl/evt_tick_stage.sv
module evt_tick_stage
   import evt_timer_pkg::*;
#(
   parameter int DIV        = 4,
   parameter bit CLR_ON_RST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic pulse_o
);

   if (DIV < 1) begin : g_bad_div
      $error("evt_tick_stage: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      // Divide by one: every enable is passed straight on.
      assign pulse_o = en_i;
      logic unused_pass;
      assign unused_pass = ^{clk, rst_n, clr_i};
   end else begin : g_count
      localparam int            CW   = stage_width(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          at_last;

      assign at_last = (cnt_q == LAST);
      assign pulse_o = en_i && at_last;

      always_comb begin
         cnt_d = cnt_q;
         if (clr_i) begin
            cnt_d = '0;
         end else if (en_i) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
         end
      end

      if (CLR_ON_RST) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            cnt_q <= cnt_d;
         end
         logic unused_rst;
         assign unused_rst = rst_n;
      end
   end

endmodule

// File: rtl/evt_tick_chain.sv
module evt_tick_chain
   import evt_timer_pkg::*;
#(
   parameter int INSTR_DIV  = 4,
   parameter int PRESCALE   = 4,
   parameter int OVF_BITS   = 8,
   parameter bit CLR_ON_RST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);

   // en[g] enables stage g; en[TICK_STAGES] is the final tick.
   logic [TICK_STAGES:0] en;
   assign en[0] = 1'b1;

   for (genvar g = 0; g < TICK_STAGES; g++) begin : g_stage
      evt_tick_stage #(
         .DIV       (stage_ratio(g, INSTR_DIV, PRESCALE, OVF_BITS)),
         .CLR_ON_RST(CLR_ON_RST)
      ) stage_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_i  (clr_i),
         .en_i   (en[g]),
         .pulse_o(en[g+1])
      );
   end

   assign tick_o = en[TICK_STAGES];

endmodule

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("evt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], async_i};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/evt_jiffy_core.sv
module evt_jiffy_core
   import evt_timer_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter bit CLR_ON_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cap_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] interval_o,
   output logic             ready_o,
   output logic             overrun_o
);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] res_q, res_d;
   hs_flags_t        flg_q, flg_d;

   // Capture has priority over a coincident tick: the result takes the
   // pre-increment count and the counter restarts at zero.
   always_comb begin
      cnt_d = cnt_q;
      res_d = res_q;
      if (cap_i) begin
         res_d = cnt_q;
         cnt_d = '0;
      end else if (tick_i) begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   // A capture always leaves data ready; overrun builds up only when
   // unread data is overwritten without a strobe in the same cycle.
   always_comb begin
      flg_d = flg_q;
      if (cap_i) begin
         flg_d.ready   = 1'b1;
         flg_d.overrun = ~ack_i & (flg_q.overrun | flg_q.ready);
      end else if (ack_i) begin
         flg_d = '0;
      end
   end

   if (CLR_ON_RST) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            res_q <= '0;
         end else begin
            cnt_q <= cnt_d;
            res_q <= res_d;
         end
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         cnt_q <= cnt_d;
         res_q <= res_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= flg_d;
   end

   assign count_o    = cnt_q;
   assign interval_o = res_q;
   assign ready_o    = flg_q.ready;
   assign overrun_o  = flg_q.overrun;

endmodule

// File: rtl/evt_interval_timer.sv
module evt_interval_timer
   import evt_timer_pkg::*;
#(
   parameter int INSTR_DIV      = 4,
   parameter int PRESCALE       = 4,
   parameter int OVF_BITS       = 8,
   parameter int CNT_W          = 16,
   parameter int SYNC_STAGES    = 2,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             rd_ack_i,
   output logic [CNT_W-1:0] interval_o,
   output logic             ready_o,
   output logic             overrun_o
);

   localparam int TICK_PERIOD = INSTR_DIV * PRESCALE * (1 << OVF_BITS);

   if (INSTR_DIV < 1 || PRESCALE < 1) begin : g_bad_ratio
      $error("evt_interval_timer: divide ratios must be at least 1");
   end
   if (OVF_BITS < 1 || OVF_BITS > 16) begin : g_bad_ovf
      $error("evt_interval_timer: OVF_BITS must be 1..16");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("evt_interval_timer: CNT_W must be at least 2");
   end

   logic             evt_pulse;
   logic             tick;
   logic [CNT_W-1:0] jiffy_cnt;

   evt_edge_sync #(
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(evt_i),
      .rise_o (evt_pulse)
   );

   evt_tick_chain #(
      .INSTR_DIV (INSTR_DIV),
      .PRESCALE  (PRESCALE),
      .OVF_BITS  (OVF_BITS),
      .CLR_ON_RST(CLEAR_ON_RESET)
   ) tick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (evt_pulse),
      .tick_o(tick)
   );

   evt_jiffy_core #(
      .CNT_W     (CNT_W),
      .CLR_ON_RST(CLEAR_ON_RESET)
   ) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .cap_i     (evt_pulse),
      .ack_i     (rd_ack_i),
      .count_o   (jiffy_cnt),
      .interval_o(interval_o),
      .ready_o   (ready_o),
      .overrun_o (overrun_o)
   );

endmodule

// File: rtl/evt_interval_timer_chk.sv
module evt_interval_timer_chk #(
   parameter int CNT_W       = 16,
   parameter int TICK_PERIOD = 4096
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_ack_i,
   input logic             evt_pulse,
   input logic             tick,
   input logic [CNT_W-1:0] jiffy,
   input logic [CNT_W-1:0] interval_o,
   input logic             ready_o,
   input logic             overrun_o
);

   // Cycles since the divider last restarted (tick or capture).
   int unsigned gap_q;
   logic        seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= 0;
         seen_q <= 1'b0;
      end else if (tick || evt_pulse) begin
         gap_q  <= 1;
         seen_q <= 1'b1;
      end else if (gap_q <= TICK_PERIOD) begin
         gap_q  <= gap_q + 1;
      end
   end

   // R1: ticks are spaced exactly one tick period after a restart
   assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && seen_q) |-> (gap_q == TICK_PERIOD));

   // R1, R9: a tick advances the count by one, modulo 2^CNT_W
   assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !evt_pulse) |=> (jiffy == $past(jiffy) + 1'b1));

   assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !evt_pulse) |=> $stable(jiffy));

   // R2: one rising edge gives a single-cycle capture pulse
   assert_single_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |=> !evt_pulse);

   // R3, R5: capture takes the pre-increment count
   assert_capture_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |=> (interval_o == $past(jiffy)));

   assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_pulse |=> $stable(interval_o));

   // R4: capture restarts the count and the divider phase
   assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |=> (jiffy == '0));

   assert_divider_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse && (TICK_PERIOD > 1)) |=> !tick);

   // R6: capture sets ready; a strobe without capture clears it
   assert_capture_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |=> ready_o);

   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack_i && !evt_pulse) |=> (!ready_o && !overrun_o));

   // R7: overwrite of unread data sets overrun, which stays until a strobe
   assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse && ready_o && !rd_ack_i) |=> overrun_o);

   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && !rd_ack_i) |=> overrun_o);

   assert_overrun_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |-> ready_o);

endmodule

bind evt_interval_timer evt_interval_timer_chk #(
   .CNT_W      (CNT_W),
   .TICK_PERIOD(TICK_PERIOD)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_ack_i  (rd_ack_i),
   .evt_pulse (evt_pulse),
   .tick      (tick),
   .jiffy     (jiffy_cnt),
   .interval_o(interval_o),
   .ready_o   (ready_o),
   .overrun_o (overrun_o)
);

// File: tb/evt_interval_timer_tb_top.sv
module evt_interval_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int WATCHDOG   = 195000;

   // Bench build: INSTR_DIV=1, PRESCALE=1, OVF_BITS=1 gives a 2-cycle tick.
   // Expected interval for captures G cycles apart: floor((G-1)/2) mod 2^16.

   typedef struct packed {
      logic [31:0] gap;
      logic [3:0]  high;
      logic        ack;
      logic        chk;
      logic        ovr;
      logic [15:0] exp;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VEC [NVEC] = '{
      '{32'd10,   4'd2, 1'b1, 1'b0, 1'b0, 16'd0},    // first interval: value invalid (R8)
      '{32'd5,    4'd1, 1'b0, 1'b1, 1'b0, 16'd2},    // R4
      '{32'd6,    4'd2, 1'b1, 1'b1, 1'b1, 16'd2},    // R5 tick on capture edge, R7 overrun
      '{32'd7,    4'd3, 1'b1, 1'b1, 1'b0, 16'd3},    // R4
      '{32'd40,   4'd2, 1'b1, 1'b1, 1'b0, 16'd19},   // R5
      '{32'd255,  4'd1, 1'b0, 1'b1, 1'b0, 16'd127},  // R1
      '{32'd256,  4'd2, 1'b1, 1'b1, 1'b1, 16'd127},  // R5, R7
      '{32'd1001, 4'd2, 1'b1, 1'b1, 1'b0, 16'd500},  // R1
      '{32'd2048, 4'd1, 1'b1, 1'b1, 1'b0, 16'd1023}  // R1, R5
   };

   logic             clk;
   logic             rst_n;
   logic             evt_i;
   logic             rd_ack_i;
   logic [CNT_W-1:0] interval_o;
   logic             ready_o;
   logic             overrun_o;

   int  checks;
   int  failures;
   int  since;
   bit  done;

   evt_interval_timer #(
      .INSTR_DIV     (1),
      .PRESCALE      (1),
      .OVF_BITS      (1),
      .CNT_W         (CNT_W),
      .SYNC_STAGES   (2),
      .CLEAR_ON_RESET(1'b0)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .rd_ack_i  (rd_ack_i),
      .interval_o(interval_o),
      .ready_o   (ready_o),
      .overrun_o (overrun_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic step();
      @(negedge clk);
      since++;
   endtask

   task automatic wait_to(input int n);
      while (since < n) step();
   endtask

   // Raise the event gap cycles after the previous rise, hold it high.
   task automatic fire(input int gap, input int high);
      wait_to(gap);
      evt_i = 1'b1;
      since = 0;
      repeat (high) step();
      evt_i = 1'b0;
   endtask

   task automatic ack_and_check(input string req);
      rd_ack_i = 1'b1;
      step();
      rd_ack_i = 1'b0;
      check(ready_o == 1'b0, req, "ready after read strobe", ready_o, 0);
      check(overrun_o == 1'b0, req, "overrun after read strobe", overrun_o, 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", WATCHDOG, 0);
         summary();
      end
   end

   initial begin
      logic [CNT_W-1:0] held;
      checks   = 0;
      failures = 0;
      since    = 0;
      done     = 1'b0;
      rst_n    = 1'b0;
      evt_i    = 1'b0;
      rd_ack_i = 1'b0;
      repeat (3) @(negedge clk);

      // R8: flags clear in reset
      check(ready_o == 1'b0, "R8", "ready in reset", ready_o, 0);
      check(overrun_o == 1'b0, "R8", "overrun in reset", overrun_o, 0);
      rst_n = 1'b1;
      since = 0;

      // R10: a read strobe with nothing ready changes nothing
      rd_ack_i = 1'b1;
      step();
      rd_ack_i = 1'b0;
      step();
      check(ready_o == 1'b0, "R10", "ready after idle strobe", ready_o, 0);
      check(overrun_o == 1'b0, "R10", "overrun after idle strobe", overrun_o, 0);

      // Vector table: capture appears three cycles after the rise (R2)
      for (int i = 0; i < NVEC; i++) begin
         fire(int'(VEC[i].gap), int'(VEC[i].high));
         wait_to(3);
         check(ready_o == 1'b1, "R6", $sformatf("ready after capture %0d", i), ready_o, 1);
         if (VEC[i].chk)
            check(interval_o == VEC[i].exp, "R4",
                  $sformatf("interval vector %0d gap %0d", i, VEC[i].gap),
                  interval_o, VEC[i].exp);
         check(overrun_o == VEC[i].ovr, "R7", $sformatf("overrun vector %0d", i),
               overrun_o, VEC[i].ovr);
         if (VEC[i].ack) ack_and_check("R6");
      end

      // R6: strobe in the capture cycle keeps ready set, no overrun
      fire(10, 1);
      wait_to(3);
      check(ready_o == 1'b1, "R6", "ready before coincident strobe", ready_o, 1);
      fire(12, 1);
      wait_to(2);
      rd_ack_i = 1'b1;
      step();
      rd_ack_i = 1'b0;
      check(ready_o == 1'b1, "R6", "ready with strobe on capture", ready_o, 1);
      check(overrun_o == 1'b0, "R6", "overrun with strobe on capture", overrun_o, 0);
      check(interval_o == 16'd5, "R4", "interval gap 12", interval_o, 5);
      ack_and_check("R6");

      // R10: interval value untouched by a strobe when nothing is ready
      held = interval_o;
      rd_ack_i = 1'b1;
      step();
      rd_ack_i = 1'b0;
      check(interval_o == held, "R10", "interval after idle strobe", interval_o, held);

      // R9: 65537 ticks wrap to 1
      fire(131075, 1);
      wait_to(3);
      check(interval_o == 16'd1, "R9", "interval after wrap", interval_o, 1);
      check(overrun_o == 1'b0, "R9", "overrun after wrap", overrun_o, 0);
      ack_and_check("R9");

      // R2: a long pulse gives one capture only
      fire(20, 10);
      check(interval_o == 16'd9, "R2", "interval gap 20", interval_o, 9);
      rd_ack_i = 1'b1;
      evt_i = 1'b1;
      step();
      rd_ack_i = 1'b0;
      repeat (6) step();
      evt_i = 1'b0;
      check(ready_o == 1'b0, "R2", "ready after held-high pulse", ready_o, 0);
      fire(30, 1);
      wait_to(3);
      check(interval_o == 16'd14, "R2", "interval measured from rise", interval_o, 14);
      check(ready_o == 1'b1, "R2", "ready after next rise", ready_o, 1);

      // R8: reset mid-run clears the flags
      rst_n = 1'b0;
      step();
      check(ready_o == 1'b0, "R8", "ready after mid-run reset", ready_o, 0);
      check(overrun_o == 1'b0, "R8", "overrun after mid-run reset", overrun_o, 0);
      rst_n = 1'b1;
      step();

      done = 1'b1;
      summary();
   end

endmodule